// File: doc/BRIEF.md
# System Clock Controller with Protected Registers and Wait Mode

This block produces the clock enables for a small microcontroller. The CPU clock enable comes from one of two sources. The first is the main oscillator, which is the block clock divided by a programmable ratio. The second is a sub-oscillator tick input. The block also produces the peripheral enables at full rate, at one eighth and at one thirty-second of the main clock.

Software programs three byte-wide registers over a simple write/read bus:

- a lock register at address 0;
- clock control register A at address 1;
- clock control register B at address 2.

Both clock control registers accept writes only while the unlock bit in the lock register is 1.

A wait request idles the CPU clock enable. Wait mode ends only when an interrupt is present, its level is strictly above the processor priority, and the interrupt enable flag is set. On exit the block gives a one-cycle wake pulse. CPU enables resume at the next divider tick.

Top module: `sysclk_ctrl`

## Requirements
- R1: A write to address 1 or address 2 changes nothing while lock register bit 0 is 0. Writing lock bit 0 to 1 permits such writes from the next cycle.
- R2: `reg_rdata` shows the register at `reg_addr` one cycle after the address is presented. Register layouts:
  - address 0: bit 0 is the unlock bit;
  - address 1 (register A): bit 0 = divide-by-8, bit 1 = sub select, bit 2 = main stop, bit 3 = peripheral stop, bit 4 = sub pins oscillator use;
  - address 2 (register B): bits 1:0 = divider code.
  All other bits read 0. Reset values are 0x00, 0x01 and 0x00.
- R3: With register A bit 0 at 0, the divider code in register B sets the main-clock CPU enable period: 00 gives 1 cycle, 01 gives 2, 10 gives 4 and 11 gives 16.
- R4: With register A bit 0 at 1, the CPU enable period is 8 cycles whatever the divider code.
- R5: With register A bit 1 at 1, `cpu_ce` pulses once, one cycle after each `sub_tick` pulse, instead of following the divider.
- R6: A new source or ratio takes effect only when the current period ends, so no shortened enable period appears.
- R7: `main_osc_en` is the inverse of register A bit 2. `sub_osc_pins` equals register A bit 4.
- R8: A `wait_req` pulse sets `in_wait` in the next cycle. While `in_wait` is 1, `cpu_ce` stays 0.
- R9: Wait mode ends only in a cycle where all three hold: `irq_valid` is 1, `irq_iflag` is 1, and `irq_level` is strictly greater than `cpu_ipl`.
- R10: On exit, `wake` is 1 for exactly one cycle and `in_wait` clears at the same time. A `wait_req` in the exit cycle is ignored. CPU enables resume at the next tick.
- R11: `f8_en` pulses once every 8 cycles and `f32_en` once every 32. `f1_en` is otherwise 1. While in wait with register A bit 3 at 1, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| sub_tick | input | 1 | Sub-oscillator tick, one cycle wide |
| wait_req | input | 1 | Request to enter wait mode |
| irq_valid | input | 1 | An enabled interrupt is pending |
| irq_level | input | 3 | Level of the pending interrupt |
| cpu_ipl | input | 3 | Current processor priority level |
| irq_iflag | input | 1 | Interrupt enable flag |
| cpu_ce | output | 1 | CPU clock enable |
| f1_en | output | 1 | Full-rate peripheral enable |
| f8_en | output | 1 | Divide-by-8 peripheral strobe |
| f32_en | output | 1 | Divide-by-32 peripheral strobe |
| main_osc_en | output | 1 | Main oscillator run enable |
| sub_osc_pins | output | 1 | Sub oscillator pins in oscillator use |
| wake | output | 1 | One-cycle wait-exit pulse |
| in_wait | output | 1 | Wait mode active |

## Verification
Two pairs of events can land in the same cycle. The first is a register write that changes the ratio arriving exactly as the current divider period ends. The bench changes the divider code at many phases of the running count, and a per-cycle reference model flags any enable that comes early or late. The second is a wait request arriving in the same cycle as a qualifying interrupt while already waiting. The bench raises both together and expects the wake to win: `in_wait` falls, `wake` pulses once, and the request has no effect.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  typedef enum logic [1:0] {
    A_LOCK = 2'd0,
    A_CTLA = 2'd1,
    A_CTLB = 2'd2
  } reg_addr_e;

  // control register A, bit 4 down to bit 0
  typedef struct packed {
    logic sub_pins;
    logic periph_stop;
    logic main_off;
    logic sub_sel;
    logic div8;
  } ctla_t;

  localparam int RATIO_W = 5;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic div8,
                                                  input logic [1:0] code);
    logic [RATIO_W-1:0] r;
    if (div8) r = 5'd8;
    else begin
      case (code)
        2'b00:   r = 5'd1;
        2'b01:   r = 5'd2;
        2'b10:   r = 5'd4;
        default: r = 5'd16;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/sysclk_regs.sv
module sysclk_regs
  import sysclk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctla_t             ctla,
  output logic [1:0]        code
);

  localparam int CTLA_W = $bits(ctla_t);

  logic              unlock;
  logic [DATA_W-1:0] rd;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:CTLA_W];

  always_comb begin
    rd = '0;
    case (addr)
      A_LOCK:  rd[0] = unlock;
      A_CTLA:  rd[CTLA_W-1:0] = ctla;
      A_CTLB:  rd[1:0] = code;
      default: rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unlock <= 1'b0;
      ctla   <= '{sub_pins: 1'b0, periph_stop: 1'b0, main_off: 1'b0,
                  sub_sel: 1'b0, div8: 1'b1};
      code   <= 2'b00;
      rdata  <= '0;
    end else begin
      rdata <= rd;
      if (we) begin
        case (addr)
          A_LOCK: unlock <= wdata[0];
          A_CTLA: if (unlock) ctla <= ctla_t'(wdata[CTLA_W-1:0]);
          A_CTLB: if (unlock) code <= wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  // R1: locked writes leave both control registers untouched
  assert_locked_write_R1: assert property (@(posedge clk) disable iff (rst)
    (we && addr != A_LOCK && !unlock) |=> ($stable(ctla) && $stable(code)));

  // R2: reserved read bits stay zero
  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:CTLA_W] == '0);

endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
  import sysclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sub_tick,
  input  logic               pend_sel,
  input  logic [RATIO_W-1:0] pend_ratio,
  output logic               tick
);

  localparam int CNT_W = RATIO_W - 1;

  logic [CNT_W-1:0]   cnt;
  logic               act_sel;
  logic [RATIO_W-1:0] act_ratio;

  assign tick = act_sel ? sub_tick
                        : ({1'b0, cnt} == act_ratio - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      act_sel   <= 1'b0;
      act_ratio <= RATIO_W'(8);
    end else if (tick) begin
      cnt       <= '0;
      act_sel   <= pend_sel;
      act_ratio <= pend_ratio;
    end else if (!act_sel) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R3: only power-of-two ratios are ever active
  assert_ratio_legal_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(act_ratio) == 1);

  // R6: the count never runs past the active period
  assert_no_overrun_R6: assert property (@(posedge clk) disable iff (rst)
    !act_sel |-> ({1'b0, cnt} < act_ratio));

endmodule

// File: rtl/sysclk_waitctl.sv
module sysclk_waitctl #(
  parameter int PRIO_W  = 3,
  parameter int PCNT_W  = 5,
  parameter int F8_BITS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wait_req,
  input  logic              irq_valid,
  input  logic [PRIO_W-1:0] irq_level,
  input  logic [PRIO_W-1:0] cpu_ipl,
  input  logic              irq_iflag,
  input  logic              periph_stop,
  output logic              cpu_ce,
  output logic              wake,
  output logic              in_wait,
  output logic              f1_en,
  output logic              f8_en,
  output logic              f32_en
);

  logic [PCNT_W-1:0] pcnt;
  logic              wake_c;
  logic              gate;

  assign wake_c = in_wait && irq_valid && irq_iflag && (irq_level > cpu_ipl);
  assign gate   = in_wait && periph_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_wait <= 1'b0;
      wake    <= 1'b0;
      cpu_ce  <= 1'b0;
      pcnt    <= '0;
      f1_en   <= 1'b0;
      f8_en   <= 1'b0;
      f32_en  <= 1'b0;
    end else begin
      wake   <= wake_c;
      cpu_ce <= tick && !in_wait;
      if (wake_c)        in_wait <= 1'b0;
      else if (wait_req) in_wait <= 1'b1;
      pcnt   <= pcnt + PCNT_W'(1);
      f1_en  <= !gate;
      f8_en  <= (pcnt[F8_BITS-1:0] == '1) && !gate;
      f32_en <= (pcnt == '1) && !gate;
    end
  end

  // R8: no CPU enable follows a waiting cycle
  assert_ce_idle_R8: assert property (@(posedge clk) disable iff (rst)
    in_wait |=> !cpu_ce);

  // R9: a wake pulse needs a qualified interrupt one cycle earlier
  assert_wake_qual_R9: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(irq_valid && irq_iflag && (irq_level > cpu_ipl)));

  // R10: wake is a single pulse and ends wait mode
  assert_wake_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    wake |-> (!in_wait && $fell(in_wait)));

  // R11: stopped peripheral enables while waiting
  assert_periph_gate_R11: assert property (@(posedge clk) disable iff (rst)
    (in_wait && periph_stop) |=> (!f1_en && !f8_en && !f32_en));

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PRIO_W  = 3,
  parameter int PCNT_W  = 5,
  parameter int F8_BITS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sub_tick,
  input  logic              wait_req,
  input  logic              irq_valid,
  input  logic [PRIO_W-1:0] irq_level,
  input  logic [PRIO_W-1:0] cpu_ipl,
  input  logic              irq_iflag,
  output logic              cpu_ce,
  output logic              f1_en,
  output logic              f8_en,
  output logic              f32_en,
  output logic              main_osc_en,
  output logic              sub_osc_pins,
  output logic              wake,
  output logic              in_wait
);

  ctla_t              ctla;
  logic [1:0]         code;
  logic [RATIO_W-1:0] pend_ratio;
  logic               tick;

  assign pend_ratio   = ratio_of(ctla.div8, code);
  assign main_osc_en  = !ctla.main_off;
  assign sub_osc_pins = ctla.sub_pins;

  sysclk_regs #(.DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctla  (ctla),
    .code  (code)
  );

  sysclk_divider u_div (
    .clk        (clk),
    .rst        (rst),
    .sub_tick   (sub_tick),
    .pend_sel   (ctla.sub_sel),
    .pend_ratio (pend_ratio),
    .tick       (tick)
  );

  sysclk_waitctl #(
    .PRIO_W  (PRIO_W),
    .PCNT_W  (PCNT_W),
    .F8_BITS (F8_BITS)
  ) u_wait (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .wait_req    (wait_req),
    .irq_valid   (irq_valid),
    .irq_level   (irq_level),
    .cpu_ipl     (cpu_ipl),
    .irq_iflag   (irq_iflag),
    .periph_stop (ctla.periph_stop),
    .cpu_ce      (cpu_ce),
    .wake        (wake),
    .in_wait     (in_wait),
    .f1_en       (f1_en),
    .f8_en       (f8_en),
    .f32_en      (f32_en)
  );

  // R7: a stopped main oscillator is reflected on its enable pin
  assert_osc_off_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_CTLA && $past(reg_rdata[0] == 1'b1 && reg_addr == A_LOCK)
     && reg_wdata[2] && reg_rdata[0]) |=> !main_osc_en);

endmodule

// File: tb/sysclk_ctrl_test.sv
`timescale 1ns/100ps
module sysclk_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sub_tick = 1'b0;
  logic       wait_req = 1'b0;
  logic       irq_valid = 1'b0;
  logic [2:0] irq_level = 3'd0;
  logic [2:0] cpu_ipl = 3'd0;
  logic       irq_iflag = 1'b0;
  logic       cpu_ce, f1_en, f8_en, f32_en, main_osc_en, sub_osc_pins, wake, in_wait;

  int runs = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysclk_ctrl uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sub_tick(sub_tick),
    .wait_req(wait_req), .irq_valid(irq_valid), .irq_level(irq_level),
    .cpu_ipl(cpu_ipl), .irq_iflag(irq_iflag), .cpu_ce(cpu_ce),
    .f1_en(f1_en), .f8_en(f8_en), .f32_en(f32_en), .main_osc_en(main_osc_en),
    .sub_osc_pins(sub_osc_pins), .wake(wake), .in_wait(in_wait)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_unlock, m_ca, m_code, m_rd;
  int m_cnt, m_asub, m_aratio;
  int m_wait, m_wake, m_ce, m_pc, m_f1, m_f8, m_f32;

  function automatic int ratio_m(int ca, int cd);
    if (ca % 2 == 1) return 8;
    if (cd == 3) return 16;
    return 1 << cd;
  endfunction

  always @(posedge clk) begin
    int rd, tk, gate, nwait;
    if (rst) begin
      m_unlock = 0; m_ca = 1; m_code = 0; m_rd = 0;
      m_cnt = 0; m_asub = 0; m_aratio = 8;
      m_wait = 0; m_wake = 0; m_ce = 0; m_pc = 0;
      m_f1 = 0; m_f8 = 0; m_f32 = 0;
    end else begin
      rd = (reg_addr == 0) ? m_unlock : (reg_addr == 1) ? m_ca :
           (reg_addr == 2) ? m_code : 0;
      tk = m_asub ? int'(sub_tick) : int'(m_cnt == m_aratio - 1);
      gate = m_wait && ((m_ca >> 3) % 2 == 1);
      m_wake = m_wait && irq_valid && irq_iflag && (irq_level > cpu_ipl);
      m_ce = tk && !m_wait;
      nwait = m_wake ? 0 : (wait_req ? 1 : m_wait);
      m_f1 = !gate;
      m_f8 = (m_pc % 8 == 7) && !gate;
      m_f32 = (m_pc == 31) && !gate;
      m_pc = (m_pc + 1) % 32;
      if (tk) begin
        m_cnt = 0;
        m_asub = (m_ca >> 1) % 2;
        m_aratio = ratio_m(m_ca, m_code);
      end else if (!m_asub) m_cnt = m_cnt + 1;
      m_wait = nwait;
      m_rd = rd;
      if (reg_we) begin
        if (reg_addr == 0) m_unlock = reg_wdata[0];
        else if (reg_addr == 1 && m_unlock == 1) m_ca = reg_wdata[4:0];
        else if (reg_addr == 2 && m_unlock == 1) m_code = reg_wdata[1:0];
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cpu_ce == m_ce, "R3 R4 R5 R6 cpu_ce", cpu_ce, m_ce);
      chk(reg_rdata == m_rd, "R2 rdata", reg_rdata, m_rd);
      chk(in_wait == m_wait, "R8 in_wait", in_wait, m_wait);
      chk(wake == m_wake, "R10 wake", wake, m_wake);
      chk(f1_en == m_f1 && f8_en == m_f8 && f32_en == m_f32, "R11 periph",
          {f1_en, f8_en, f32_en}, m_f1 * 4 + m_f8 * 2 + m_f32);
      chk(main_osc_en == ((m_ca >> 2) % 2 == 0), "R7 main_osc_en",
          main_osc_en, int'((m_ca >> 2) % 2 == 0));
      chk(sub_osc_pins == ((m_ca >> 4) % 2), "R7 sub_osc_pins",
          sub_osc_pins, (m_ca >> 4) % 2);
    end
  end

  // sub oscillator: one tick every fifth cycle
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 5;
      sub_tick = (ph == 0);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    @(negedge clk);
    reg_addr = 2'(a);
    @(negedge clk);
    chk(reg_rdata == 8'(exp), req, reg_rdata, exp);
  endtask

  task automatic count_ce(input int n, input int exp, input string req);
    int k = 0;
    repeat (n) begin
      @(negedge clk);
      if (cpu_ce) k++;
    end
    chk(k == exp, req, k, exp);
  endtask

  task automatic count_f(input int n, input int e1, input int e8, input int e32,
                         input string req);
    int k1 = 0, k8 = 0, k32 = 0;
    repeat (n) begin
      @(negedge clk);
      if (f1_en) k1++;
      if (f8_en) k8++;
      if (f32_en) k32++;
    end
    chk(k1 == e1 && k8 == e8 && k32 == e32, req, k1 * 10000 + k8 * 100 + k32,
        e1 * 10000 + e8 * 100 + e32);
  endtask

  task automatic pulse_wait();
    @(negedge clk);
    wait_req = 1'b1;
    @(negedge clk);
    wait_req = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // reset state: R2 and R7
    rd_chk(1, 8'h01, "R2 reset ctrl A");
    rd_chk(2, 8'h00, "R2 reset ctrl B");
    chk(main_osc_en == 1'b1, "R7 reset osc on", main_osc_en, 1);
    count_ce(64, 8, "R4 reset divide by 8");

    // R1: locked write ignored
    wr(1, 8'h00);
    wr(2, 8'h01);
    rd_chk(1, 8'h01, "R1 locked ctrl A");
    rd_chk(2, 8'h00, "R1 locked ctrl B");
    count_ce(64, 8, "R1 ratio unchanged");

    // unlock, then R4: code ignored under divide-by-8
    wr(0, 8'h01);
    rd_chk(0, 8'h01, "R2 lock readback");
    wr(2, 8'hFF);
    rd_chk(2, 8'h03, "R2 reserved bits zero");
    repeat (20) @(negedge clk);
    count_ce(64, 8, "R4 code ignored");

    // R3: each divider code, changed at varied phases (R6)
    wr(1, 8'h00);
    repeat (20) @(negedge clk);
    count_ce(64, 4, "R3 divide by 16");
    wr(2, 8'h01);
    repeat (3) @(negedge clk);
    wr(2, 8'h00);
    repeat (20) @(negedge clk);
    count_ce(64, 64, "R3 divide by 1");
    wr(2, 8'h01);
    repeat (20) @(negedge clk);
    count_ce(64, 32, "R3 divide by 2");
    wr(2, 8'h02);
    repeat (20) @(negedge clk);
    count_ce(64, 16, "R3 divide by 4");
    for (int ph = 0; ph < 6; ph++) begin
      wr(2, 8'h03);
      repeat (ph + 5) @(negedge clk);
      wr(2, 8'h02);
      repeat (ph) @(negedge clk);
    end

    // R5: sub oscillator selected
    wr(1, 8'h02);
    repeat (40) @(negedge clk);
    count_ce(60, 12, "R5 sub ticks");

    // R7: main off, pins to oscillator use
    wr(1, 8'h16);
    @(negedge clk);
    chk(main_osc_en == 1'b0, "R7 main stopped", main_osc_en, 0);
    chk(sub_osc_pins == 1'b1, "R7 pins oscillator", sub_osc_pins, 1);
    wr(1, 8'h00);
    repeat (40) @(negedge clk);

    // R8: wait without peripheral stop
    pulse_wait();
    chk(in_wait == 1'b1, "R8 enter wait", in_wait, 1);
    count_ce(16, 0, "R8 no cpu_ce in wait");
    count_f(32, 32, 4, 1, "R11 periph run in wait");

    // R9: unqualified interrupts do not wake
    @(negedge clk);
    irq_valid = 1'b1; irq_level = 3'd3; cpu_ipl = 3'd3; irq_iflag = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_wait == 1'b1, "R9 equal level no wake", in_wait, 1);
    irq_level = 3'd5; irq_iflag = 1'b0;
    repeat (4) @(negedge clk);
    chk(in_wait == 1'b1, "R9 iflag clear no wake", in_wait, 1);
    irq_iflag = 1'b1; irq_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(in_wait == 1'b1, "R9 no irq no wake", in_wait, 1);

    // R10: qualified wake, together with a wait request
    irq_valid = 1'b1; wait_req = 1'b1;
    @(negedge clk);
    irq_valid = 1'b0; wait_req = 1'b0;
    chk(wake == 1'b1, "R10 wake pulse", wake, 1);
    chk(in_wait == 1'b0, "R10 wait cleared", in_wait, 0);
    @(negedge clk);
    chk(wake == 1'b0, "R10 wake single", wake, 0);
    count_ce(16, 4, "R10 cpu_ce resumes");

    // R11: peripheral stop in wait
    wr(1, 8'h08);
    count_f(64, 64, 8, 2, "R11 strobes outside wait");
    pulse_wait();
    count_f(40, 0, 0, 0, "R11 periph stopped");
    irq_valid = 1'b1; irq_level = 3'd7; cpu_ipl = 3'd2;
    @(negedge clk);
    irq_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(in_wait == 1'b0, "R11 wake after stop", in_wait, 0);
    count_f(32, 32, 4, 1, "R11 periph restart");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule